// File: doc/BRIEF.md
# SPI Register and Queue Command Front End

This block is the serial slave port of a small packet controller. A host drives chip select low, clocks a command over SPI mode 0, and the block works out from the first two bits whether the command targets the internal register bus or one of the two packet queues. A register command carries a 16-bit header with four byte enables and a dword address, followed by one 16-bit data word. A queue command carries a one-byte header and then streams bytes for as long as chip select stays low.

The SPI pins are sampled by the much faster system clock through synchronizer chains, so the block sees SCLK edges as single-cycle events. Register commands become single-cycle requests on a simple register bus. Queue commands become byte strobes toward a transmit queue or pops from a show-ahead receive queue. An input from the queue DMA logic locks out register traffic while a queue transfer is in progress.

Top module: `spi_cmd_front`

## Requirements
- R1: The first two bits after chip select falls are the opcode, MSB first: 00 register read, 01 register write, 10 queue read, 11 queue write. Queue commands have an 8-bit header (opcode plus six ignored bits). Register commands have a 16-bit header: bits 15:14 opcode, 13:10 byte enables, 9:2 dword address, 1:0 ignored.
- R2: A register access goes to the upper word of the dword when header enables 11:10 are both zero and 13:12 are not, and to the lower word otherwise. The bus byte address is {dword, upper, 0}, and the bus byte strobes are the two enables of the chosen word.
- R3: A register write takes 16 data bits after the header, low byte first and each byte MSB first. It issues exactly one bus write with the assembled word after the 16th data bit.
- R4: A register read issues exactly one bus read, and reg_rdata_i is taken in the request cycle. MISO carries the word from the first data bit on, low byte first and MSB first, with any lane whose strobe is clear read as zero.
- R5: A register command whose chosen word has no enabled lane makes no bus access, and a read of that kind returns 0x0000.
- R6: If sda_active_i is high when a register header completes, that command makes no bus access and a read returns 0x0000. Queue commands are served regardless of sda_active_i.
- R7: A queue write gives one tx_q_valid_o strobe per eight data bits, carrying the byte MSB first, until chip select rises.
- R8: A queue read pops the receive queue when its header completes and again after every eight data bits. Each popped head byte is shifted out on MISO MSB first.
- R9: Raising chip select aborts any command. A partial register write or a partial queue byte produces no strobe, and the next command decodes from a fresh header.
- R10: MISO is 0 while chip select is high and during every header.
- R11: After reset, no request or strobe is active and MISO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, several times faster than SCLK |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | SPI clock (mode 0) |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | SPI data from host |
| miso_o | output | 1 | SPI data to host, 0 when not selected |
| sda_active_i | input | 1 | Queue DMA in progress; locks out register access |
| reg_req_o | output | 1 | Register bus request, one cycle |
| reg_we_o | output | 1 | Register bus write (1) or read (0) |
| reg_addr_o | output | 10 | Register bus byte address, bit 0 always 0 |
| reg_be_o | output | 2 | Register bus byte strobes |
| reg_wdata_o | output | 16 | Register bus write data |
| reg_rdata_i | input | 16 | Register bus read data, valid in request cycle |
| tx_q_valid_o | output | 1 | Transmit queue byte strobe |
| tx_q_data_o | output | 8 | Transmit queue byte |
| rx_q_data_i | input | 8 | Receive queue head byte (show-ahead) |
| rx_q_pop_o | output | 1 | Receive queue pop |

## Verification
The hardest case to reach from the pins is a command cut short in the middle: chip select has to rise after the opcode has been decoded but before the 16th data bit of a register write, or part of the way through a queue byte. Only then does the abort path run with a live command. The bench drives exact bit counts per transfer and deliberately stops a register write and a queue write short. It then follows each one with a full command to show that decoding restarts cleanly. The lockout input is set for some random commands, so that register and queue traffic both meet it.

// File: rtl/spi_cmd_front_pkg.sv
package spi_cmd_front_pkg;
  typedef enum logic [1:0] {
    OP_REG_RD  = 2'b00,
    OP_REG_WR  = 2'b01,
    OP_FIFO_RD = 2'b10,
    OP_FIFO_WR = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_HDR, ST_REG_RD, ST_REG_WR, ST_FIFO_RD, ST_FIFO_WR, ST_DONE
  } st_e;

  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 16;
  localparam int DW_AW    = 8;
  localparam int REG_AW   = DW_AW + 2;
  localparam int LANES    = WORD_W / BYTE_W;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_act_o,
  output logic mosi_o
);
  localparam int NPIN = 3;
  localparam logic [NPIN-1:0] RST_VAL = 3'b010; // {sclk, cs_n, mosi}

  logic [NPIN-1:0] pin_raw;
  logic [NPIN-1:0] pin_s;
  logic            sclk_prev_q;

  assign pin_raw = {sclk_i, cs_ni, mosi_i};

  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[g]}};
      else         chain_q <= {chain_q[STAGES-2:0], pin_raw[g]};
    end
    assign pin_s[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_prev_q <= 1'b0;
    else         sclk_prev_q <= pin_s[2];
  end

  assign cs_act_o    = ~pin_s[1];
  assign mosi_o      = pin_s[0];
  assign sclk_rise_o = cs_act_o &  pin_s[2] & ~sclk_prev_q;
  assign sclk_fall_o = cs_act_o & ~pin_s[2] &  sclk_prev_q;
endmodule

// File: rtl/spi_hdr_decode.sv
module spi_hdr_decode
  import spi_cmd_front_pkg::*;
(
  input  logic [WORD_W-1:0] hdr_i,
  input  logic              sda_i,
  output op_e               op_o,
  output logic [REG_AW-1:0] addr_o,
  output logic [LANES-1:0]  be_o,
  output logic              access_ok_o
);
  logic upper;

  assign op_o   = op_e'(hdr_i[15:14]);
  // upper word only when no lower lane is requested
  assign upper  = (hdr_i[11:10] == 2'b00) && (hdr_i[13:12] != 2'b00);
  assign be_o   = upper ? hdr_i[13:12] : hdr_i[11:10];
  assign addr_o = {hdr_i[9:2], upper, 1'b0};
  assign access_ok_o = !sda_i && (be_o != '0);
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_front_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              cs_act_i,
  input  logic              mosi_i,
  input  logic              sda_i,
  output logic              out_bit_o,
  output logic              reg_req_o,
  output logic              reg_we_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [LANES-1:0]  reg_be_o,
  output logic [WORD_W-1:0] reg_wdata_o,
  input  logic [WORD_W-1:0] reg_rdata_i,
  output logic              tx_vld_o,
  output logic [BYTE_W-1:0] tx_data_o,
  input  logic [BYTE_W-1:0] rx_data_i,
  output logic              rx_pop_o
);
  st_e               st_q;
  logic [3:0]        cnt_q;
  logic [WORD_W-1:0] sr_q, out_q, nxt;
  logic              rd_pend_q, ok_q;
  op_e               dec_op;
  logic [REG_AW-1:0] dec_addr;
  logic [LANES-1:0]  dec_be;
  logic              dec_ok;

  assign nxt = {sr_q[WORD_W-2:0], mosi_i};

  spi_hdr_decode u_dec (
    .hdr_i       (nxt),
    .sda_i       (sda_i),
    .op_o        (dec_op),
    .addr_o      (dec_addr),
    .be_o        (dec_be),
    .access_ok_o (dec_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_HDR; cnt_q <= '0; sr_q <= '0; out_q <= '0;
      rd_pend_q <= 1'b0; ok_q <= 1'b0;
      reg_req_o <= 1'b0; reg_we_o <= 1'b0; reg_addr_o <= '0;
      reg_be_o <= '0; reg_wdata_o <= '0;
      tx_vld_o <= 1'b0; tx_data_o <= '0; rx_pop_o <= 1'b0;
    end else begin
      reg_req_o <= 1'b0;
      tx_vld_o  <= 1'b0;
      rx_pop_o  <= 1'b0;
      if (!cs_act_i) begin
        st_q <= ST_HDR; cnt_q <= '0; sr_q <= '0; out_q <= '0;
        rd_pend_q <= 1'b0;
      end else begin
        if (rd_pend_q) begin
          rd_pend_q <= 1'b0;
          out_q <= {reg_be_o[0] ? reg_rdata_i[7:0]  : 8'h00,
                    reg_be_o[1] ? reg_rdata_i[15:8] : 8'h00};
        end
        unique case (st_q)
          ST_HDR: if (rise_i) begin
            sr_q  <= nxt;
            cnt_q <= cnt_q + 4'd1;
            if (cnt_q == 4'd7 && nxt[7]) begin
              cnt_q <= '0;
              if (nxt[6]) st_q <= ST_FIFO_WR;
              else begin
                st_q     <= ST_FIFO_RD;
                out_q    <= {rx_data_i, 8'h00};
                rx_pop_o <= 1'b1;
              end
            end else if (cnt_q == 4'd15) begin
              cnt_q      <= '0;
              reg_addr_o <= dec_addr;
              reg_be_o   <= dec_be;
              ok_q       <= dec_ok;
              if (dec_op == OP_REG_WR) st_q <= ST_REG_WR;
              else begin
                st_q <= ST_REG_RD;
                if (dec_ok) begin
                  reg_req_o <= 1'b1;
                  reg_we_o  <= 1'b0;
                  rd_pend_q <= 1'b1;
                end
              end
            end
          end
          ST_REG_WR: if (rise_i) begin
            sr_q  <= nxt;
            cnt_q <= cnt_q + 4'd1;
            if (cnt_q == 4'd15) begin
              st_q <= ST_DONE;
              if (ok_q) begin
                reg_req_o   <= 1'b1;
                reg_we_o    <= 1'b1;
                reg_wdata_o <= {nxt[7:0], nxt[15:8]};
              end
            end
          end
          ST_REG_RD: begin
            if (rise_i) begin
              cnt_q <= cnt_q + 4'd1;
              if (cnt_q == 4'd15) begin
                st_q  <= ST_DONE;
                out_q <= '0;
              end
            end else if (fall_i && cnt_q != '0) begin
              out_q <= {out_q[WORD_W-2:0], 1'b0};
            end
          end
          ST_FIFO_WR: if (rise_i) begin
            sr_q  <= nxt;
            cnt_q <= cnt_q + 4'd1;
            if (cnt_q == 4'd7) begin
              cnt_q     <= '0;
              tx_vld_o  <= 1'b1;
              tx_data_o <= nxt[7:0];
            end
          end
          ST_FIFO_RD: begin
            if (rise_i) begin
              cnt_q <= cnt_q + 4'd1;
              if (cnt_q == 4'd7) begin
                cnt_q    <= '0;
                out_q    <= {rx_data_i, 8'h00};
                rx_pop_o <= 1'b1;
              end
            end else if (fall_i && cnt_q != '0) begin
              out_q <= {out_q[WORD_W-2:0], 1'b0};
            end
          end
          default: out_q <= '0;
        endcase
      end
    end
  end

  assign out_bit_o = out_q[WORD_W-1];
endmodule

// File: rtl/spi_cmd_front.sv
module spi_cmd_front
  import spi_cmd_front_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  input  logic              sda_active_i,
  output logic              reg_req_o,
  output logic              reg_we_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [LANES-1:0]  reg_be_o,
  output logic [WORD_W-1:0] reg_wdata_o,
  input  logic [WORD_W-1:0] reg_rdata_i,
  output logic              tx_q_valid_o,
  output logic [BYTE_W-1:0] tx_q_data_o,
  input  logic [BYTE_W-1:0] rx_q_data_i,
  output logic              rx_q_pop_o
);
  logic rise, fall, cs_act, mosi_s, out_bit;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (sclk_i),
    .cs_ni       (cs_ni),
    .mosi_i      (mosi_i),
    .sclk_rise_o (rise),
    .sclk_fall_o (fall),
    .cs_act_o    (cs_act),
    .mosi_o      (mosi_s)
  );

  spi_cmd_engine u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rise_i      (rise),
    .fall_i      (fall),
    .cs_act_i    (cs_act),
    .mosi_i      (mosi_s),
    .sda_i       (sda_active_i),
    .out_bit_o   (out_bit),
    .reg_req_o   (reg_req_o),
    .reg_we_o    (reg_we_o),
    .reg_addr_o  (reg_addr_o),
    .reg_be_o    (reg_be_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_rdata_i (reg_rdata_i),
    .tx_vld_o    (tx_q_valid_o),
    .tx_data_o   (tx_q_data_o),
    .rx_data_i   (rx_q_data_i),
    .rx_pop_o    (rx_q_pop_o)
  );

  // raw pin gate: released pad reads as 0
  assign miso_o = ~cs_ni & out_bit;
endmodule

// File: rtl/spi_cmd_front_chk.sv
module spi_cmd_front_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       miso_o,
  input logic       sda_active_i,
  input logic       reg_req_o,
  input logic [1:0] reg_be_o,
  input logic       tx_q_valid_o,
  input logic       rx_q_pop_o
);
  // R10
  miso_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !miso_o);
  // R6
  sda_lockout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |-> !$past(sda_active_i));
  // R5
  lanes_present_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |-> (reg_be_o != 2'b00));
  // R3
  single_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |=> !reg_req_o);
  // R7
  single_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_q_valid_o |=> !tx_q_valid_o);
  // R8
  single_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_q_pop_o |=> !rx_q_pop_o);
  // R1
  one_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_req_o, tx_q_valid_o, rx_q_pop_o}));
endmodule

bind spi_cmd_front spi_cmd_front_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_ni        (cs_ni),
  .miso_o       (miso_o),
  .sda_active_i (sda_active_i),
  .reg_req_o    (reg_req_o),
  .reg_be_o     (reg_be_o),
  .tx_q_valid_o (tx_q_valid_o),
  .rx_q_pop_o   (rx_q_pop_o)
);

// File: tb/spi_cmd_front_bench.sv
module spi_cmd_front_bench;
  localparam int H = 6;

  logic clk = 0, rst_n = 0;
  logic sclk = 0, cs_n = 1, mosi = 0, sda = 0;
  logic miso, req, we, txv, pop;
  logic [9:0] addr;
  logic [1:0] be;
  logic [15:0] wdata, rdata;
  logic [7:0] txd, rxd;

  int checks = 0, fails = 0;
  int wr_n = 0, rd_n = 0, tx_n = 0, pop_n = 0;
  logic [9:0] wr_addr; logic [1:0] wr_be; logic [15:0] wr_data;
  logic [7:0] tx_log [64];
  bit done = 0;

  always #4 clk = ~clk;

  function automatic logic [15:0] rd_val(logic [9:0] a);
    return {a[7:0] ^ 8'hC3, a[9:2] + 8'h3D};
  endfunction
  function automatic logic [7:0] q_byte(int i);
    return 8'(i * 37 + 11);
  endfunction

  assign rdata = rd_val(addr);
  assign rxd   = q_byte(pop_n);

  spi_cmd_front u_spi_cmd_front (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .sda_active_i(sda), .reg_req_o(req), .reg_we_o(we),
    .reg_addr_o(addr), .reg_be_o(be), .reg_wdata_o(wdata), .reg_rdata_i(rdata),
    .tx_q_valid_o(txv), .tx_q_data_o(txd), .rx_q_data_i(rxd), .rx_q_pop_o(pop)
  );

  always @(posedge clk) begin
    if (req && we) begin wr_n <= wr_n + 1; wr_addr <= addr; wr_be <= be; wr_data <= wdata; end
    if (req && !we) rd_n <= rd_n + 1;
    if (txv) begin tx_log[tx_n % 64] <= txd; tx_n <= tx_n + 1; end
    if (pop) pop_n <= pop_n + 1;
  end

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic spi_run(input logic [63:0] bits, input int n, output logic [63:0] rx);
    rx = '0;
    cs_n = 0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      mosi = bits[n-1-i];
      repeat (H) @(negedge clk);
      rx = {rx[62:0], miso};
      sclk = 1;
      repeat (H) @(negedge clk);
      sclk = 0;
    end
    repeat (H) @(negedge clk);
    cs_n = 1; mosi = 0;
    repeat (4*H) @(negedge clk);
  endtask

  function automatic logic [15:0] reg_hdr(logic wr, logic [3:0] en, logic [7:0] dw);
    return {1'b0, wr, en, dw, 2'b00};
  endfunction

  // expected bus view of a register command
  function automatic logic [1:0] exp_be(logic [3:0] en);
    return (en[1:0] == 0 && en[3:2] != 0) ? en[3:2] : en[1:0];
  endfunction
  function automatic logic [9:0] exp_addr(logic [3:0] en, logic [7:0] dw);
    return {dw, (en[1:0] == 0 && en[3:2] != 0), 1'b0};
  endfunction

  task automatic do_reg_wr(logic [3:0] en, logic [7:0] dw, logic [15:0] d, logic lock, string r);
    logic [63:0] rx; int w0;
    logic ok;
    w0 = wr_n;
    sda = lock;
    ok = !lock && exp_be(en) != 0;
    spi_run({32'h0, reg_hdr(1, en, dw), d[7:0], d[15:8]}, 32, rx);
    sda = 0;
    check({r, " write count"}, wr_n - w0, ok ? 1 : 0);
    if (ok) begin
      check({r, " write addr"}, wr_addr, exp_addr(en, dw));
      check({r, " write be"}, wr_be, exp_be(en));
      check({r, " write data"}, wr_data, d);
    end
  endtask

  task automatic do_reg_rd(logic [3:0] en, logic [7:0] dw, logic lock, string r);
    logic [63:0] rx; int r0;
    logic ok; logic [1:0] b; logic [15:0] v; logic [15:0] e;
    r0 = rd_n;
    sda = lock;
    b = exp_be(en);
    ok = !lock && b != 0;
    v = rd_val(exp_addr(en, dw));
    e = ok ? {b[0] ? v[7:0] : 8'h00, b[1] ? v[15:8] : 8'h00} : 16'h0;
    spi_run({32'h0, reg_hdr(0, en, dw), 16'h0}, 32, rx);
    sda = 0;
    check({r, " read count"}, rd_n - r0, ok ? 1 : 0);
    check({r, " read data"}, rx[15:0], e);
    check("R10 header miso", rx[31:16], 0);
  endtask

  task automatic do_fifo_wr(int nb, logic lock, string r);
    logic [63:0] v, rx; logic [7:0] b [6]; int t0;
    t0 = tx_n; v = 64'hC0;
    sda = lock;
    for (int k = 0; k < nb; k++) begin b[k] = 8'($urandom); v = (v << 8) | 64'(b[k]); end
    spi_run(v, 8 + 8*nb, rx);
    sda = 0;
    check({r, " tx count"}, tx_n - t0, nb);
    for (int k = 0; k < nb; k++) check({r, " tx byte"}, tx_log[(t0 + k) % 64], b[k]);
  endtask

  task automatic do_fifo_rd(int nb, logic lock, string r);
    logic [63:0] rx; int p0;
    p0 = pop_n;
    sda = lock;
    spi_run(64'h80 << (8*nb), 8 + 8*nb, rx);
    sda = 0;
    check({r, " pop count"}, pop_n - p0, nb + 1);
    for (int k = 0; k < nb; k++)
      check({r, " rx byte"}, rx[(nb-1-k)*8 +: 8], q_byte(p0 + k));
    check("R10 header miso", rx[8*nb +: 8], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] rx; int w0, t0;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    // R11
    check("R11 miso", miso, 0);
    check("R11 req", req, 0);
    check("R11 tx", txv, 0);
    check("R11 pop", pop, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check("R11 idle after reset", {miso, req, txv, pop}, 0);

    do_reg_wr(4'b0011, 8'h5A, 16'h1234, 0, "R3 R2 lower");
    do_reg_wr(4'b1100, 8'h21, 16'hBEEF, 0, "R2 upper");
    do_reg_wr(4'b0110, 8'h07, 16'hA55A, 0, "R2 mixed");
    do_reg_rd(4'b0011, 8'h33, 0, "R4 full");
    do_reg_rd(4'b0001, 8'h44, 0, "R4 low lane");
    do_reg_rd(4'b1000, 8'h45, 0, "R4 upper lane");
    do_reg_rd(4'b0000, 8'h46, 0, "R5 no lanes");
    do_reg_wr(4'b0000, 8'h46, 16'h7777, 0, "R5 no lanes");
    do_reg_rd(4'b0011, 8'h10, 1, "R6 locked");
    do_reg_wr(4'b1111, 8'h10, 16'h0F0F, 1, "R6 locked");
    do_fifo_wr(3, 1, "R6 R7 locked");
    do_fifo_rd(2, 1, "R6 R8 locked");
    do_fifo_wr(6, 0, "R7");
    do_fifo_rd(6, 0, "R8");
    do_reg_rd(4'b0011, 8'hFF, 0, "R1 after fifo");

    // R9 abort mid write and mid queue byte
    w0 = wr_n;
    spi_run({44'h0, reg_hdr(1, 4'b0011, 8'h12), 4'hA}, 20, rx);
    check("R9 partial reg write", wr_n - w0, 0);
    t0 = tx_n;
    spi_run({51'h0, 8'hC0, 5'h15}, 13, rx);
    check("R9 partial tx byte", tx_n - t0, 0);
    do_reg_wr(4'b0011, 8'h13, 16'hC0DE, 0, "R9 after abort");
    check("R10 idle miso", miso, 0);

    for (int i = 0; i < 40; i++) begin
      logic [3:0] en; logic [7:0] dw; logic lock; int ty;
      en = 4'($urandom); dw = 8'($urandom); lock = ($urandom % 4) == 0;
      ty = $urandom % 4;
      case (ty)
        0: do_reg_rd(en, dw, lock, "R4 rand");
        1: do_reg_wr(en, dw, 16'($urandom), lock, "R3 rand");
        2: do_fifo_rd(1 + $urandom % 5, lock, "R8 rand");
        default: do_fifo_wr(1 + $urandom % 5, lock, "R7 rand");
      endcase
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule